// File: doc/BRIEF.md
# Masked Packed Float-to-Quadword Converter

This block turns up to eight IEEE-754 single-precision values into signed 64-bit integers, always rounding toward zero. Every lane has its own mask bit. When masking is on, a lane whose bit is clear does not take its converted value. In merge mode that lane keeps its value from a supplied prior destination vector. In zeroing mode the lane is forced to zero. A length code picks 2, 4 or 8 active lanes, which is a 128-, 256- or 512-bit result, and every result bit above that width reads zero. A broadcast option makes every active lane convert the lowest source element.

An operand that has no signed 64-bit form returns the integer-indefinite pattern 0x8000_0000_0000_0000 and raises an invalid flag. Any lane that drops nonzero fraction bits raises a precision flag. Both flags are sticky and are cleared only by reset. Results are registered, so each operand set presented before a rising clock edge appears at the outputs after that edge.

Top module: `cvtq_vec_unit`

## Requirements
- R1: Result lane j (bits [64j+63:64j]) holds source element j (bits [32j+31:32j]) converted to a signed 64-bit integer with truncation toward zero, so 1.5 gives 1 and -2.75 gives -2.
- R2: lenCode 2'b00 makes lanes 0-1 active, 2'b01 makes lanes 0-3 active, and 2'b10 or 2'b11 make all eight lanes active.
- R3: An active lane takes its converted value when maskOn is 0, whatever laneMask holds, or when laneMask[j] is 1.
- R4: An active lane that is masked off (maskOn 1, laneMask[j] 0) keeps priorDst bits [64j+63:64j] when zeroMode is 0 and reads zero when zeroMode is 1.
- R5: With bcastOn at 1, every active lane converts srcVec[31:0] in place of its own element.
- R6: Every result bit above the active vector length is zero, whatever the mask, the merge setting and priorDst hold.
- R7: A NaN of either sign, an infinity of either sign, or any value of magnitude 2^63 or more gives 0x8000_0000_0000_0000 and sets invalidFlag. The one exception is exactly -2^63 (0xDF000000), which converts to the same pattern without raising invalid.
- R8: inexactFlag sets when a written lane drops nonzero fraction bits. A denormal input converts to zero and sets inexactFlag, and a zero input sets nothing.
- R9: The flags are sticky. Only lanes that are active and written can set them, so a masked-off or inactive lane holding a NaN leaves both flags unchanged.
- R10: The result and both flags are registered. Each updates on the rising edge that follows its inputs, and reset (rstN low at an edge) clears all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| srcVec | input | 256 | Eight packed single-precision source elements |
| priorDst | input | 512 | Prior destination value, used by merge mode |
| laneMask | input | 8 | Per-lane write mask |
| maskOn | input | 1 | Enables masking. When 0 every active lane is written |
| zeroMode | input | 1 | 1 zeroes masked-off lanes, 0 merges them |
| bcastOn | input | 1 | Broadcasts source element 0 to all lanes |
| lenCode | input | 2 | Active lane count: 00 two lanes, 01 four lanes, 1x eight lanes |
| resultOut | output | 512 | Registered packed quadword result |
| invalidFlag | output | 1 | Sticky invalid-operation flag |
| inexactFlag | output | 1 | Sticky precision flag |

## Verification
The bench targets the edge of the integer range. It applies +2^63, exactly -2^63, and values just below 2^63. A converter that compares magnitudes carelessly either flags -2^63 as invalid or wraps +2^63 to a negative number. It also sends NaNs and infinities to lanes that are masked off or lie beyond the active length. A design that gathers flags from every lane, rather than from the written lanes only, would raise invalid there. Fractional, denormal and negative operands find truncation that rounds the wrong way, or a precision flag that is missed. Merge, zeroing and broadcast runs with priorDst set to all ones show stale upper bits or the wrong lane source.

// File: rtl/cvtq_pkg.sv
package cvtq_pkg;
  localparam int NUM_LANES = 8;
  localparam int SP_W      = 32;
  localparam int QW_W      = 64;
  localparam int EXP_W     = 8;
  localparam int FRAC_W    = 23;
  localparam int EXP_BIAS  = 127;
  localparam int SRC_W     = NUM_LANES * SP_W;
  localparam int DST_W     = NUM_LANES * QW_W;
  localparam logic [QW_W-1:0] INDEFINITE = {1'b1, {(QW_W-1){1'b0}}};

  // Strobes from control to datapath, one bit per lane
  typedef struct packed {
    logic [NUM_LANES-1:0] laneActive;  // lane lies inside vector length
    logic [NUM_LANES-1:0] laneTake;    // lane receives converted value
    logic [NUM_LANES-1:0] laneKeep;    // lane keeps prior destination
    logic                 bcast;       // all lanes read element 0
  } laneCtrl_t;
endpackage

// File: rtl/cvtq_ctrl.sv
module cvtq_ctrl
  import cvtq_pkg::*;
(
  input  logic [NUM_LANES-1:0] laneMask,
  input  logic                 maskOn,
  input  logic                 zeroMode,
  input  logic                 bcastOn,
  input  logic [1:0]           lenCode,
  output laneCtrl_t            ctrl
);
  localparam int CNT_W = $clog2(NUM_LANES + 1);

  logic [CNT_W-1:0] laneCount;

  always_comb begin
    unique case (lenCode)
      2'b00:   laneCount = CNT_W'(2);
      2'b01:   laneCount = CNT_W'(4);
      default: laneCount = CNT_W'(NUM_LANES);
    endcase
  end

  for (genvar j = 0; j < NUM_LANES; j++) begin : g_lane
    logic inRange;
    logic selected;
    assign inRange  = (CNT_W'(j) < laneCount);
    assign selected = !maskOn || laneMask[j];
    assign ctrl.laneActive[j] = inRange;
    assign ctrl.laneTake[j]   = inRange && selected;
    assign ctrl.laneKeep[j]   = inRange && !selected && !zeroMode;
  end

  assign ctrl.bcast = bcastOn;
endmodule

// File: rtl/cvtq_lane_cvt.sv
module cvtq_lane_cvt
  import cvtq_pkg::*;
(
  input  logic [SP_W-1:0] fpIn,
  output logic [QW_W-1:0] intOut,
  output logic            isInvalid,
  output logic            isInexact
);
  localparam int MANT_W  = FRAC_W + 1;
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam int EXP_OVF = EXP_BIAS + QW_W - 1;   // exponent of 2^63
  localparam int SH_W    = $clog2(QW_W);

  logic              signBit;
  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;
  logic [MANT_W-1:0] mant;
  logic [SH_W-1:0]   shAmt;
  logic [MANT_W-1:0] lostMask;
  logic [QW_W-1:0]   mag;

  assign signBit   = fpIn[SP_W-1];
  assign expField  = fpIn[SP_W-2 -: EXP_W];
  assign fracField = fpIn[FRAC_W-1:0];
  assign mant      = {1'b1, fracField};

  always_comb begin
    intOut    = '0;
    isInvalid = 1'b0;
    isInexact = 1'b0;
    shAmt     = '0;
    lostMask  = '0;
    mag       = '0;
    if (int'(expField) == EXP_MAX) begin
      intOut    = INDEFINITE;
      isInvalid = 1'b1;
    end else if (int'(expField) < EXP_BIAS) begin
      // magnitude below one, denormals included
      isInexact = (expField != '0) || (fracField != '0);
    end else if (int'(expField) >= EXP_OVF) begin
      intOut = INDEFINITE;
      if (!(signBit && int'(expField) == EXP_OVF && fracField == '0))
        isInvalid = 1'b1;
    end else begin
      shAmt = SH_W'(int'(expField) - EXP_BIAS);
      if (int'(shAmt) >= FRAC_W) begin
        mag = {{(QW_W-MANT_W){1'b0}}, mant} << (int'(shAmt) - FRAC_W);
      end else begin
        mag       = {{(QW_W-MANT_W){1'b0}}, mant >> (FRAC_W - int'(shAmt))};
        lostMask  = ~({MANT_W{1'b1}} << (FRAC_W - int'(shAmt)));
        isInexact = |(mant & lostMask);
      end
      intOut = signBit ? (~mag + QW_W'(1)) : mag;
    end
  end
endmodule

// File: rtl/cvtq_datapath.sv
module cvtq_datapath
  import cvtq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  laneCtrl_t        ctrl,
  input  logic [SRC_W-1:0] srcVec,
  input  logic [DST_W-1:0] priorDst,
  output logic [DST_W-1:0] resultOut,
  output logic             invalidFlag,
  output logic             inexactFlag
);
  logic [DST_W-1:0]     nextResult;
  logic [NUM_LANES-1:0] laneInv;
  logic [NUM_LANES-1:0] laneInx;

  for (genvar j = 0; j < NUM_LANES; j++) begin : g_lane
    logic [SP_W-1:0] laneSrc;
    logic [QW_W-1:0] laneInt;
    logic            cvtInv;
    logic            cvtInx;

    assign laneSrc = ctrl.bcast ? srcVec[SP_W-1:0] : srcVec[j*SP_W +: SP_W];

    cvtq_lane_cvt u_cvt (
      .fpIn      (laneSrc),
      .intOut    (laneInt),
      .isInvalid (cvtInv),
      .isInexact (cvtInx)
    );

    always_comb begin
      if (ctrl.laneTake[j])
        nextResult[j*QW_W +: QW_W] = laneInt;
      else if (ctrl.laneKeep[j])
        nextResult[j*QW_W +: QW_W] = priorDst[j*QW_W +: QW_W];
      else
        nextResult[j*QW_W +: QW_W] = '0;
    end

    assign laneInv[j] = ctrl.laneTake[j] && cvtInv;
    assign laneInx[j] = ctrl.laneTake[j] && cvtInx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultOut   <= '0;
      invalidFlag <= 1'b0;
      inexactFlag <= 1'b0;
    end else begin
      resultOut   <= nextResult;
      invalidFlag <= invalidFlag || (|laneInv);
      inexactFlag <= inexactFlag || (|laneInx);
    end
  end
endmodule

// File: rtl/cvtq_vec_unit.sv
module cvtq_vec_unit
  import cvtq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SRC_W-1:0]     srcVec,
  input  logic [DST_W-1:0]     priorDst,
  input  logic [NUM_LANES-1:0] laneMask,
  input  logic                 maskOn,
  input  logic                 zeroMode,
  input  logic                 bcastOn,
  input  logic [1:0]           lenCode,
  output logic [DST_W-1:0]     resultOut,
  output logic                 invalidFlag,
  output logic                 inexactFlag
);
  laneCtrl_t ctrl;

  cvtq_ctrl u_ctrl (
    .laneMask (laneMask),
    .maskOn   (maskOn),
    .zeroMode (zeroMode),
    .bcastOn  (bcastOn),
    .lenCode  (lenCode),
    .ctrl     (ctrl)
  );

  cvtq_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .srcVec      (srcVec),
    .priorDst    (priorDst),
    .resultOut   (resultOut),
    .invalidFlag (invalidFlag),
    .inexactFlag (inexactFlag)
  );
endmodule

// File: rtl/cvtq_vec_unit_chk.sv
module cvtq_vec_unit_chk
  import cvtq_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [SRC_W-1:0]     srcVec,
  input logic [DST_W-1:0]     priorDst,
  input logic [NUM_LANES-1:0] laneMask,
  input logic                 maskOn,
  input logic                 zeroMode,
  input logic                 bcastOn,
  input logic [1:0]           lenCode,
  input logic [DST_W-1:0]     resultOut,
  input logic                 invalidFlag,
  input logic                 inexactFlag
);
  // R10: reset clears result and flags
  a_r10_reset_clear: assert property (@(posedge clk)
    !rstN |=> (resultOut == '0 && !invalidFlag && !inexactFlag));

  // R6: two-lane length leaves upper bits zero
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (lenCode == 2'b00) |=> (resultOut[DST_W-1:2*QW_W] == '0));

  // R4: merge keeps the prior lane 0
  a_r4_merge_lane0: assert property (@(posedge clk) disable iff (!rstN)
    (maskOn && !zeroMode && !laneMask[0]) |=> (resultOut[QW_W-1:0] == $past(priorDst[QW_W-1:0])));

  // R4: zeroing clears masked-off lane 1
  a_r4_zero_lane1: assert property (@(posedge clk) disable iff (!rstN)
    (maskOn && zeroMode && !laneMask[1]) |=> (resultOut[2*QW_W-1:QW_W] == '0));

  // R7: a written NaN or infinity in lane 0 gives indefinite and invalid
  a_r7_special_lane0: assert property (@(posedge clk) disable iff (!rstN)
    ((!maskOn || laneMask[0]) && srcVec[SP_W-2 -: EXP_W] == '1)
      |=> (resultOut[QW_W-1:0] == INDEFINITE && invalidFlag));

  // R9: flags are sticky
  a_r9_invalid_sticky: assert property (@(posedge clk) disable iff (!rstN)
    invalidFlag |=> invalidFlag);
  a_r9_inexact_sticky: assert property (@(posedge clk) disable iff (!rstN)
    inexactFlag |=> inexactFlag);
endmodule

bind cvtq_vec_unit cvtq_vec_unit_chk u_chk (.*);

// File: tb/cvtq_vec_unit_test.sv
module cvtq_vec_unit_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [255:0] srcVec = '0;
  logic [511:0] priorDst = '0;
  logic [7:0]   laneMask = '0;
  logic         maskOn = 1'b0;
  logic         zeroMode = 1'b0;
  logic         bcastOn = 1'b0;
  logic [1:0]   lenCode = 2'b00;
  logic [511:0] resultOut;
  logic         invalidFlag;
  logic         inexactFlag;

  int checks = 0;
  int errors = 0;
  logic modelInv = 1'b0;
  logic modelInx = 1'b0;

  localparam logic [63:0] INDEF = 64'h8000_0000_0000_0000;

  always #5 clk = ~clk;

  cvtq_vec_unit uut (
    .clk(clk), .rstN(rstN), .srcVec(srcVec), .priorDst(priorDst),
    .laneMask(laneMask), .maskOn(maskOn), .zeroMode(zeroMode),
    .bcastOn(bcastOn), .lenCode(lenCode), .resultOut(resultOut),
    .invalidFlag(invalidFlag), .inexactFlag(inexactFlag)
  );

  initial begin
    #(20000 * 10);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // Reference conversion by exact wide scaling: value = mant * 2^(e-150)
  task automatic refLane(input logic [31:0] f, output logic [63:0] q,
                         output logic inv, output logic inx);
    logic [299:0] full;
    logic [149:0] ip;
    int e;
    e = int'(f[30:23]);
    q = '0; inv = 1'b0; inx = 1'b0;
    if (e == 255) begin
      q = INDEF; inv = 1'b1;
    end else if (e == 0) begin
      inx = (f[22:0] != 0);
    end else begin
      full = {276'd0, 1'b1, f[22:0]} << e;
      ip   = full[299:150];
      inx  = (full[149:0] != 0);
      if (ip >= (150'd1 << 63)) begin
        q = INDEF;
        inv = !(f[31] && ip == (150'd1 << 63) && !inx);
        inx = 1'b0;
      end else begin
        q = f[31] ? -ip[63:0] : ip[63:0];
      end
    end
  endtask

  task automatic refVec(output logic [511:0] expv, output logic anyInv,
                        output logic anyInx);
    int lanes;
    logic [63:0] q;
    logic inv, inx;
    lanes = (lenCode == 2'b00) ? 2 : (lenCode == 2'b01) ? 4 : 8;
    expv = '0; anyInv = 1'b0; anyInx = 1'b0;
    for (int j = 0; j < 8; j++) begin
      if (j < lanes) begin
        if (!maskOn || laneMask[j]) begin
          refLane(bcastOn ? srcVec[31:0] : srcVec[j*32 +: 32], q, inv, inx);
          expv[j*64 +: 64] = q;
          anyInv |= inv; anyInx |= inx;
        end else if (!zeroMode) begin
          expv[j*64 +: 64] = priorDst[j*64 +: 64];
        end
      end
    end
  endtask

  task automatic check(input string tag, input logic [511:0] act,
                       input logic [511:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
    modelInv = 1'b0; modelInx = 1'b0;
  endtask

  // Drive at negedge, the result registers on the next rising edge
  task automatic applyOp(input string tag);
    logic [511:0] expv;
    logic ei, ex;
    refVec(expv, ei, ex);
    modelInv |= ei; modelInx |= ex;
    @(posedge clk); @(negedge clk);
    check({tag, " result"}, resultOut, expv);
    check({tag, " invalid"}, {511'd0, invalidFlag}, {511'd0, modelInv});
    check({tag, " inexact"}, {511'd0, inexactFlag}, {511'd0, modelInx});
  endtask

  task automatic setOp(input logic [255:0] s, input logic [511:0] p,
                       input logic [7:0] m, input logic mOn, input logic z,
                       input logic b, input logic [1:0] len);
    srcVec = s; priorDst = p; laneMask = m; maskOn = mOn;
    zeroMode = z; bcastOn = b; lenCode = len;
  endtask

  function automatic logic [31:0] randFloat();
    logic [31:0] r;
    r = $urandom;
    case (r[3:0])
      4'd0: return {r[31], 8'hFF, r[30:8]};      // NaN or inf
      4'd1: return {r[31], 8'h00, r[30:8]};      // zero or denormal
      4'd2: return {r[31], 8'd190, r[30:8]};     // at or above 2^63
      4'd3: return {r[31], 8'd189, r[30:8]};     // just below 2^63
      default: return {r[31], 8'(100 + ($urandom % 90)), r[30:8]};
    endcase
  endfunction

  initial begin
    logic [255:0] s;
    logic [511:0] ones;
    ones = '1;
    void'($urandom(32'd20240611));

    @(negedge clk); @(negedge clk);
    check("R10 reset result", resultOut, '0);
    check("R10 reset flags", {510'd0, invalidFlag, inexactFlag}, '0);
    rstN = 1'b1;

    // R1/R8: truncation 1.5 -> 1, -2.75 -> -2, 3.0 exact, zero
    s = '0;
    s[31:0] = 32'h3FC0_0000; s[63:32] = 32'hC030_0000;
    s[95:64] = 32'h4040_0000; s[127:96] = 32'h0000_0000;
    setOp(s, ones, 8'h00, 1'b0, 1'b0, 1'b0, 2'b01);
    applyOp("R1 R8 R3 truncation four lanes");

    // R6 R2: two lanes with all-ones prior, upper bits must be zero
    setOp(s, ones, 8'h00, 1'b1, 1'b0, 1'b0, 2'b00);
    applyOp("R6 R2 R4 merge two lanes");

    doReset();
    // R4: merge vs zero with mixed mask over eight lanes
    for (int j = 0; j < 8; j++) s[j*32 +: 32] = 32'h4100_0000 + 32'(j << 20);
    setOp(s, ones, 8'b1010_0110, 1'b1, 1'b0, 1'b0, 2'b10);
    applyOp("R4 merge eight lanes");
    setOp(s, ones, 8'b1010_0110, 1'b1, 1'b1, 1'b0, 2'b11);
    applyOp("R4 R2 zeroing eight lanes");

    // R5: broadcast lane 0
    s[31:0] = 32'hC2F6_E979;  // -123.456
    setOp(s, ones, 8'hFF, 1'b1, 1'b0, 1'b1, 2'b10);
    applyOp("R5 broadcast");

    // R9: NaN in masked-off and out-of-range lanes leaves invalid clear
    doReset();
    s = '0;
    s[63:32] = 32'h7FC0_0000; s[159:128] = 32'hFF80_0000;
    setOp(s, '0, 8'b1111_1101, 1'b1, 1'b0, 1'b0, 2'b00);
    applyOp("R9 masked NaN ignored");
    check("R9 invalid stays clear", {511'd0, invalidFlag}, '0);

    // R7: -2^63 exact, no invalid
    s = '0; s[31:0] = 32'hDF00_0000; s[63:32] = 32'h5EFF_FFFF;
    setOp(s, '0, 8'h00, 1'b0, 1'b0, 1'b0, 2'b00);
    applyOp("R7 minus 2^63 exact");
    check("R7 no invalid for -2^63", {511'd0, invalidFlag}, '0);

    // R7: +2^63, NaN, -inf
    s = '0; s[31:0] = 32'h5F00_0000; s[63:32] = 32'h7FC0_0000;
    s[95:64] = 32'hFF80_0000; s[127:96] = 32'hDF00_0001;
    setOp(s, '0, 8'h00, 1'b0, 1'b0, 1'b0, 2'b01);
    applyOp("R7 out of range");
    check("R7 invalid set", {511'd0, invalidFlag}, 512'd1);

    // R8: denormal gives zero and precision
    doReset();
    s = '0; s[31:0] = 32'h0000_0001;
    setOp(s, '0, 8'h00, 1'b0, 1'b0, 1'b0, 2'b00);
    applyOp("R8 denormal");
    check("R8 inexact set", {511'd0, inexactFlag}, 512'd1);

    // R9: flags hold across a clean operation
    s = '0; s[31:0] = 32'h4040_0000;
    setOp(s, '0, 8'h00, 1'b0, 1'b0, 1'b0, 2'b00);
    applyOp("R9 sticky hold");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      if (n % 60 == 0) doReset();
      for (int j = 0; j < 8; j++) s[j*32 +: 32] = randFloat();
      for (int j = 0; j < 16; j++) priorDst[j*32 +: 32] = $urandom;
      setOp(s, priorDst, 8'($urandom), 1'($urandom), 1'($urandom),
            ($urandom % 5) == 0, 2'($urandom));
      applyOp("R1 R3 R4 R7 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule